// File: doc/BRIEF.md
# Keyed Watchdog Timer with Reset-Out

This block is a watchdog for a small 8-bit controller. It sits on the controller's register write path and watches one write-only service address. After reset it does nothing. Software starts it by writing a two-byte key to that address, first 0x1E and then 0xE1. From then on it counts machine-cycle ticks in a 13-bit counter. Writing the same key again clears the count. Nothing else can stop it short of a reset.

If software fails to service it in time, the counter reaches its terminal value. The block then raises a one-clock internal reset request and drives a fixed-length reset-out pulse on the oscillator clock. One configuration input suppresses that drive. Counting stops in power-down. It also stops in idle when the idle-hold configuration bit is set. After a power-down exit through a low external-interrupt line, it waits until that line returns high before it counts again.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the watchdog is disabled: `rst_req_o` and `rst_pulse_o` are 0, and ticks alone never produce a reset request.
- R2: The watchdog is enabled only by a write of 0xE1 to address 0xA6 whose previous write to 0xA6 was 0x1E. Writes to any other address are ignored. Any other value in the second write cancels the sequence without effect, and the reverse order does not enable.
- R3: While enabled, each clock with `tick_i`=1 and no gating condition advances the count. After the clock edge that takes the 8191st counted tick since enabling or servicing, `rst_req_o` is 1 for exactly one clock. Without a tick, no request is raised.
- R4: Writing the key sequence while enabled restarts the count from zero.
- R5: No write can disable the watchdog. An overflow disables it, and it stays disabled until the key is written again.
- R6: On overflow `rst_pulse_o` goes high on the same edge as `rst_req_o` and stays high for exactly 96 clocks. A new overflow during a pulse does not extend it.
- R7: With `cfg_ro_off_i`=1, `rst_pulse_o` stays 0 while `rst_req_o` still fires.
- R8: While `pdown_i`=1 the count is frozen.
- R9: While `idle_i`=1 the count advances when `cfg_idle_hold_i`=0 and holds when `cfg_idle_hold_i`=1. It resumes from the held value after idle ends.
- R10: If `wake_n_i` is 0 when power-down ends, counting stays stopped until `wake_n_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Machine-cycle tick strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| idle_i | input | 1 | Controller is in idle |
| pdown_i | input | 1 | Controller is in power-down |
| wake_n_i | input | 1 | External interrupt line level, low holds off counting after power-down |
| cfg_ro_off_i | input | 1 | 1 suppresses the reset-out drive |
| cfg_idle_hold_i | input | 1 | 1 freezes counting during idle |
| rst_pulse_o | output | 1 | Reset-out pulse |
| rst_req_o | output | 1 | One-clock internal reset request |

## Verification
The key detector is tried with a vector table of write pairs: the correct pair, the reversed order, a wrong address on either byte, and a wrong value on either byte. Only the correct pair may lead to a request after exactly 8191 ticks. Directed runs split a full count into two parts around one event: a service write, a stretch of idle, a stretch of power-down, or a held-low wake line. The request then lands exactly 8191 counted ticks after the last restart, which tells a frozen count from a cleared one and from a running one. Pulse length, suppression of the drive, garbage writes while enabled, and the disabled state after overflow are each checked at the ports.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CNT_W_DEF   = 13;
  localparam int unsigned PULSE_DEF   = 96;
  localparam int unsigned BUS_W_DEF   = 8;
  localparam logic [7:0]  SVC_ADDR_DEF = 8'hA6;
  localparam logic [7:0]  KEY_A_DEF    = 8'h1E;
  localparam logic [7:0]  KEY_B_DEF    = 8'hE1;
endpackage

// File: rtl/wdt_key_det.sv
module wdt_key_det #(
  parameter int unsigned    BUS_W    = 8,
  parameter logic [BUS_W-1:0] SVC_ADDR = 8'hA6,
  parameter logic [BUS_W-1:0] KEY_A    = 8'h1E,
  parameter logic [BUS_W-1:0] KEY_B    = 8'hE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [BUS_W-1:0] wr_addr_i,
  input  logic [BUS_W-1:0] wr_data_i,
  output logic             key_ok_o
);
  logic armed_q;
  logic hit;

  assign hit      = wr_en_i && (wr_addr_i == SVC_ADDR);
  assign key_ok_o = hit && armed_q && (wr_data_i == KEY_B);

  // every service write re-evaluates the first-byte match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  armed_q <= 1'b0;
    else if (hit) armed_q <= (wr_data_i == KEY_A);
  end
endmodule

// File: rtl/wdt_gate.sv
module wdt_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic idle_i,
  input  logic pdown_i,
  input  logic wake_n_i,
  input  logic cfg_idle_hold_i,
  output logic step_o
);
  logic wake_hold_q;

  // held from power-down until the wake line returns high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_hold_q <= 1'b0;
    else         wake_hold_q <= (wake_hold_q | pdown_i) & ~wake_n_i;
  end

  assign step_o = tick_i && !pdown_i && !(idle_i && cfg_idle_hold_i)
                  && !(wake_hold_q && !wake_n_i);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_ok_i,
  input  logic step_i,
  output logic ovf_o,
  output logic req_o
);
  localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};

  logic             en_q;
  logic             req_q;
  logic [CNT_W-1:0] cnt_q;

  assign ovf_o = en_q && step_i && (cnt_q == TERM - 1'b1);
  assign req_o = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= ovf_o;
      if (ovf_o) begin
        en_q  <= 1'b0;
        cnt_q <= '0;
      end else if (key_ok_i) begin
        en_q  <= 1'b1;
        cnt_q <= '0;
      end else if (en_q && step_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned LEN = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic off_i,
  output logic pulse_o
);
  localparam int unsigned LW = $clog2(LEN + 1);
  localparam logic [LW-1:0] LOAD = LW'(LEN);

  logic [LW-1:0] left_q;
  logic          busy;

  assign busy    = (left_q != '0);
  assign pulse_o = busy && !off_i;

  // no retrigger while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              left_q <= '0;
    else if (trig_i && !busy) left_q <= LOAD;
    else if (busy)            left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = CNT_W_DEF,
  parameter int unsigned PULSE    = PULSE_DEF,
  parameter int unsigned BUS_W    = BUS_W_DEF,
  parameter logic [BUS_W-1:0] SVC_ADDR = SVC_ADDR_DEF,
  parameter logic [BUS_W-1:0] KEY_A    = KEY_A_DEF,
  parameter logic [BUS_W-1:0] KEY_B    = KEY_B_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [BUS_W-1:0] wr_addr_i,
  input  logic [BUS_W-1:0] wr_data_i,
  input  logic             idle_i,
  input  logic             pdown_i,
  input  logic             wake_n_i,
  input  logic             cfg_ro_off_i,
  input  logic             cfg_idle_hold_i,
  output logic             rst_pulse_o,
  output logic             rst_req_o
);
  logic key_ok, step, ovf;

  wdt_key_det #(
    .BUS_W(BUS_W), .SVC_ADDR(SVC_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_key (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .key_ok_o(key_ok)
  );

  wdt_gate u_gate (
    .clk_i, .rst_ni, .tick_i, .idle_i, .pdown_i, .wake_n_i,
    .cfg_idle_hold_i, .step_o(step)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .key_ok_i(key_ok), .step_i(step),
    .ovf_o(ovf), .req_o(rst_req_o)
  );

  wdt_pulse #(.LEN(PULSE)) u_pulse (
    .clk_i, .rst_ni, .trig_i(ovf), .off_i(cfg_ro_off_i), .pulse_o(rst_pulse_o)
  );
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int unsigned BUS_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [BUS_W-1:0] wr_addr_i,
  input logic [BUS_W-1:0] wr_data_i,
  input logic             idle_i,
  input logic             pdown_i,
  input logic             wake_n_i,
  input logic             cfg_ro_off_i,
  input logic             cfg_idle_hold_i,
  input logic             rst_pulse_o,
  input logic             rst_req_o
);
  AST_REQ_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R3
  AST_REQ_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !rst_req_o); // R3
  AST_PULSE_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !cfg_ro_off_i) |-> rst_pulse_o); // R6
  AST_PDOWN_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_i |=> !rst_req_o); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && cfg_idle_hold_i) |=> !rst_req_o); // R9
  AST_WAKE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdown_i && !wake_n_i) |=> !rst_req_o); // R10
endmodule

bind keyed_wdt keyed_wdt_chk #(.BUS_W(BUS_W)) u_chk (.*);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic       idle = 1'b0, pdown = 1'b0, wake_n = 1'b1;
  logic       ro_off = 1'b0, idle_hold = 1'b0;
  logic       pulse, req;
  int         total = 0, bad = 0;

  always #10 clk = ~clk;

  keyed_wdt u_keyed_wdt (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .idle_i(idle), .pdown_i(pdown),
    .wake_n_i(wake_n), .cfg_ro_off_i(ro_off), .cfg_idle_hold_i(idle_hold),
    .rst_pulse_o(pulse), .rst_req_o(req)
  );

  // {addr0, data0, addr1, data1, expect_enable}
  localparam logic [32:0] VEC [6] = '{
    {8'hA6, 8'h1E, 8'hA6, 8'hE1, 1'b1},
    {8'hA6, 8'hE1, 8'hA6, 8'h1E, 1'b0},
    {8'hA5, 8'h1E, 8'hA6, 8'hE1, 1'b0},
    {8'hA6, 8'h1E, 8'hA5, 8'hE1, 1'b0},
    {8'hA6, 8'h1E, 8'hA6, 8'hE2, 1'b0},
    {8'hA6, 8'h1F, 8'hA6, 8'hE1, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 0; wr_en = 0; idle = 0; pdown = 0; wake_n = 1;
    ro_off = 0; idle_hold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic key();
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
  endtask

  // first: tick index (1-based) after which req was first seen, 0 if never
  task automatic ticks(input int n, input bit stop, output int first, output int reqs);
    first = 0; reqs = 0;
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      if (req) begin
        reqs++;
        if (first == 0) first = i + 1;
        if (stop) break;
      end
    end
    tick = 1'b0;
  endtask

  task automatic count_pulse(input int cyc, output int hi, output int reqs);
    hi = 0; reqs = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (pulse) hi++;
      if (req) reqs++;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f, r, h, r2;
    do_reset();
    chk(req == 0, "R1 req after reset", int'(req), 0);
    chk(pulse == 0, "R1 pulse after reset", int'(pulse), 0);
    ticks(8300, 0, f, r);
    chk(r == 0, "R1 no request while disabled", r, 0);

    // key detector table
    foreach (VEC[k]) begin
      do_reset();
      wr(VEC[k][32:25], VEC[k][24:17]);
      wr(VEC[k][16:9], VEC[k][8:1]);
      ticks(8191, 0, f, r);
      chk(r == int'(VEC[k][0]), $sformatf("R2 vector %0d request count", k), r, int'(VEC[k][0]));
      if (VEC[k][0]) chk(f == 8191, "R3 table overflow tick", f, 8191);
    end

    // overflow timing and pulse
    do_reset();
    key();
    ticks(9000, 1, f, r);
    chk(f == 8191, "R3 overflow on tick 8191", f, 8191);
    chk(pulse == 1, "R6 pulse starts with request", int'(pulse), 1);
    count_pulse(120, h, r2);
    chk(h + 1 == 96, "R6 pulse length", h + 1, 96);
    chk(r2 == 0, "R3 request lasts one clock", r2, 0);
    ticks(8300, 0, f, r);
    chk(r == 0, "R5 disabled after overflow", r, 0);

    // garbage writes cannot disable
    do_reset();
    key();
    wr(8'hA6, 8'h00); wr(8'hA6, 8'hFF); wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55);
    ticks(9000, 1, f, r);
    chk(f == 8191, "R5 writes do not disable", f, 8191);

    // service restart
    do_reset();
    key();
    ticks(8000, 0, f, r);
    key();
    ticks(9000, 1, f, r);
    chk(f == 8191, "R4 service restarts count", f, 8191);

    // interrupted sequence
    do_reset();
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
    ticks(8300, 0, f, r);
    chk(r == 0, "R2 cancelled sequence", r, 0);

    // idle counts by default
    do_reset();
    key();
    idle = 1'b1;
    ticks(9000, 1, f, r);
    chk(f == 8191, "R9 idle counts with hold clear", f, 8191);
    idle = 1'b0;

    // idle hold
    do_reset();
    idle_hold = 1'b1;
    key();
    ticks(8000, 0, f, r);
    idle = 1'b1;
    ticks(500, 0, f, r);
    chk(r == 0, "R9 idle hold freezes", r, 0);
    idle = 1'b0;
    ticks(400, 1, f, r);
    chk(f == 191, "R9 count resumes after idle", f, 191);

    // power-down freeze
    do_reset();
    key();
    ticks(8000, 0, f, r);
    pdown = 1'b1;
    ticks(500, 0, f, r);
    chk(r == 0, "R8 power-down freezes", r, 0);
    pdown = 1'b0;
    ticks(400, 1, f, r);
    chk(f == 191, "R8 count resumes after power-down", f, 191);

    // wake line held low
    do_reset();
    key();
    ticks(8000, 0, f, r);
    wake_n = 1'b0; pdown = 1'b1;
    ticks(100, 0, f, r);
    pdown = 1'b0;
    ticks(300, 0, f, r);
    chk(r == 0, "R10 stopped while wake line low", r, 0);
    wake_n = 1'b1;
    ticks(400, 1, f, r);
    chk(f == 191, "R10 resumes after wake line high", f, 191);

    // drive suppressed
    do_reset();
    ro_off = 1'b1;
    key();
    ticks(9000, 1, f, r);
    chk(f == 8191, "R7 request still fires", f, 8191);
    h = int'(pulse);
    count_pulse(120, h, r2);
    h = h + int'(pulse);
    chk(h == 0, "R7 pulse suppressed", h, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule